// File: doc/BRIEF.md
# Tuner Synthesizer Two-Wire Control Port

This block is a two-wire serial (I2C) slave that holds the tuning words of a frequency-synthesizer tuner. A host addresses it with a 7-bit device address whose upper five bits are fixed at `11000` and whose lower two bits come from a board-level select code. In a write, the bytes after the address arrive in pairs. Each pair is either a divider pair (main and swallow counts) or a setup pair (charge-pump and reference settings followed by the band-switch byte). The top bit of the first byte of each pair decides which it is. A pair reaches the working registers only when its second byte is complete, so a transfer that is cut short never leaves a half-updated word. In a read, the block returns a status byte that carries the loop-lock flag and a 3-bit converter code, and it repeats that byte for as long as the host acknowledges.

SCL and SDA are resynchronised into the system clock. START is recognised as SDA falling while SCL is high, and STOP as SDA rising while SCL is high. The controller has seven states:
- `ST_IDLE`: waits for START.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: acknowledges a matching address.
- `ST_WR_BYTE`: shifts in one write byte.
- `ST_WR_ACK`: acknowledges a write byte.
- `ST_RD_BYTE`: shifts out the status byte.
- `ST_RD_ACK`: samples the host's acknowledge.

Its transitions:
- START moves any state to `ST_ADDR`, and STOP moves any state to `ST_IDLE`.
- `ST_ADDR` moves on the falling SCL edge after eight bits. It goes to `ST_ADDR_ACK` on a match and to `ST_IDLE` otherwise.
- `ST_ADDR_ACK` goes to `ST_WR_BYTE` or `ST_RD_BYTE` by the read/write bit.
- `ST_WR_BYTE` goes to `ST_WR_ACK` after eight bits, and `ST_WR_ACK` returns to `ST_WR_BYTE`.
- `ST_RD_BYTE` goes to `ST_RD_ACK` after eight bits. `ST_RD_ACK` goes back to `ST_RD_BYTE` on ACK and to `ST_IDLE` on NACK.

Top module: `tuner_i2c_regs`

## Requirements
- R1: The block acknowledges an address byte `1 1 0 0 0 a1 a0 rw` (MSB first) only when `a1 a0` equals `addr_sel_i[1:0]`. On a mismatch it never drives SDA until the next START, and the bytes that follow change no register.
- R2: If the first byte of a pair has bit7=0, that byte and the next are divider data. `main_div_o[9:3]` takes byte1 bits 6..0, `main_div_o[2:0]` takes byte2 bits 7..5, and `swallow_o[4:0]` takes byte2 bits 4..0.
- R3: If the first byte of a pair has bit7=1, it is the setup byte and the next byte is the band byte. The setup byte gives `cp_high_o`=bit6, `pump_off_o`=bit5, `ref_sel_o`={bit3,bit2} and `vt_off_o`=bit1, and its bits 4 and 0 are ignored. The band byte gives `band_o[3:0]`=bits 3..0, and its bits 7..4 are ignored.
- R4: Outputs change only when the second byte of a pair completes. A transfer that ends after the first byte of a pair leaves every output at its old value.
- R5: One write can carry several pairs (for example a divider pair and then a setup pair). A three-byte write of address plus a divider pair retunes without touching setup or band values.
- R6: Every byte of an addressed write is acknowledged by pulling SDA low during its ninth clock.
- R7: A START followed by a matching address is accepted without a preceding STOP. It discards any unpaired byte of the interrupted transfer.
- R8: A read returns, MSB first, bit7=1, bit6=`lock_i` (1=locked), bits 5..3=`111`, and bits 2..0=`adc_code_i`.
- R9: After each read byte, an ACK from the host starts another status byte. A NACK releases SDA, and SDA stays released through any further clocks until the next START.
- R10: After reset all register outputs are 0 and SDA is not driven.
- R11: A STOP in the middle of a byte aborts the transfer, leaves the outputs unchanged, and a following write is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_drive_low_o | output | 1 | 1 pulls the open-drain data line low |
| addr_sel_i | input | 2 | Board-selected low address bits |
| lock_i | input | 1 | Synthesizer lock flag, 1 = locked |
| adc_code_i | input | 3 | Converter level code |
| main_div_o | output | 10 | Main divider ratio |
| swallow_o | output | 5 | Swallow counter ratio |
| cp_high_o | output | 1 | High charge-pump current select |
| pump_off_o | output | 1 | Charge pump disable |
| ref_sel_o | output | 2 | Reference divider select code |
| vt_off_o | output | 1 | Tuning voltage output disable |
| band_o | output | 4 | Band switch enables |

## Verification
The bench sends divider and setup pairs with edge values, including all-ones bytes whose ignored bits must not leak into any field. A wrong field slice or a wrong steering bit would show up as a mismatched output. It cuts transfers short after a single byte, with a STOP inside a byte, and with a repeated START. A design that latched bytes singly, or that carried a stale first byte into the next transfer, would corrupt the registers there. It also addresses a neighbour's code, where a design with a loose address compare would acknowledge. On the read side, it acknowledges and then refuses a status byte and keeps clocking afterwards, which exposes a slave that keeps driving SDA after a NACK.

// File: rtl/tpll_pkg.sv
package tpll_pkg;
    localparam int MDIV_W = 10;
    localparam int SWL_W  = 5;
    localparam int BAND_W = 4;
    localparam int ADC_W  = 3;
    localparam int REF_W  = 2;
    localparam int SEL_W  = 2;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [BYTE_W-SEL_W-2:0] DEV_PREFIX = 5'b11000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } bus_state_e;
endpackage

// File: rtl/tpll_sync.sv
module tpll_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '1;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/tpll_bus_fsm.sv
module tpll_bus_fsm
    import tpll_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_s,
    input  logic               sda_s,
    input  logic [SEL_W-1:0]   addr_sel,
    input  logic               lock,
    input  logic [ADC_W-1:0]   adc_code,
    output logic               sda_drive_low,
    output logic               wr_stb,
    output logic [BYTE_W-1:0]  wr_byte,
    output logic               start_det,
    output logic               stop_det,
    output bus_state_e         state_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    bus_state_e          state;
    logic                scl_d, sda_d;
    logic [CNT_W-1:0]    cnt;
    logic [BYTE_W-1:0]   shreg;
    logic                rw_q, nack_q;
    logic                scl_rise, scl_fall, adr_hit;
    logic [BYTE_W-1:0]   status;

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    assign adr_hit   = (shreg[BYTE_W-1:1] == {DEV_PREFIX, addr_sel});
    assign status    = {1'b1, lock, 3'b111, adc_code};
    assign wr_byte   = shreg;
    assign state_o   = state;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
            cnt    <= '0;
            shreg  <= '0;
            rw_q   <= 1'b0;
            nack_q <= 1'b0;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
            if (start_det) begin
                state <= ST_ADDR;
                cnt   <= '0;
            end else if (stop_det) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                    end
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl_rise && cnt < FULL) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == FULL) begin
                            if (state == ST_WR_BYTE) begin
                                state <= ST_WR_ACK;
                            end else if (adr_hit) begin
                                state <= ST_ADDR_ACK;
                                rw_q  <= shreg[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw_q) begin
                                state <= ST_RD_BYTE;
                                shreg <= status;
                            end else begin
                                state <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            cnt   <= '0;
                            state <= ST_WR_BYTE;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_fall) begin
                            shreg <= {shreg[BYTE_W-2:0], 1'b1};
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST) state <= ST_RD_ACK;
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            nack_q <= sda_s;
                        end else if (scl_fall) begin
                            if (nack_q) begin
                                state <= ST_IDLE;
                            end else begin
                                state <= ST_RD_BYTE;
                                shreg <= status;
                                cnt   <= '0;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Output process
    always_comb begin
        sda_drive_low = 1'b0;
        wr_stb        = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_drive_low = 1'b1;
            ST_RD_BYTE:             sda_drive_low = ~shreg[BYTE_W-1];
            ST_WR_BYTE:             wr_stb = scl_fall && (cnt == FULL) && !start_det && !stop_det;
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/tpll_regbank.sv
module tpll_regbank
    import tpll_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [MDIV_W-1:0] main_div,
    output logic [SWL_W-1:0]  swallow,
    output logic              cp_high,
    output logic              pump_off,
    output logic [REF_W-1:0]  ref_sel,
    output logic              vt_off,
    output logic [BAND_W-1:0] band
);
    localparam int HI_W = MDIV_W - (BYTE_W - SWL_W);

    logic              second;
    logic              setup_kind;
    logic [BYTE_W-1:0] pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            second     <= 1'b0;
            setup_kind <= 1'b0;
            pend       <= '0;
            main_div   <= '0;
            swallow    <= '0;
            cp_high    <= 1'b0;
            pump_off   <= 1'b0;
            ref_sel    <= '0;
            vt_off     <= 1'b0;
            band       <= '0;
        end else if (clear) begin
            second <= 1'b0;
        end else if (wr_stb) begin
            if (!second) begin
                pend       <= wr_byte;
                setup_kind <= wr_byte[BYTE_W-1];
                second     <= 1'b1;
            end else begin
                second <= 1'b0;
                if (setup_kind) begin
                    cp_high  <= pend[6];
                    pump_off <= pend[5];
                    ref_sel  <= pend[3:2];
                    vt_off   <= pend[1];
                    band     <= wr_byte[BAND_W-1:0];
                end else begin
                    main_div <= {pend[HI_W-1:0], wr_byte[BYTE_W-1:SWL_W]};
                    swallow  <= wr_byte[SWL_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
    import tpll_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_low_o,
    input  logic [SEL_W-1:0]  addr_sel_i,
    input  logic              lock_i,
    input  logic [ADC_W-1:0]  adc_code_i,
    output logic [MDIV_W-1:0] main_div_o,
    output logic [SWL_W-1:0]  swallow_o,
    output logic              cp_high_o,
    output logic              pump_off_o,
    output logic [REF_W-1:0]  ref_sel_o,
    output logic              vt_off_o,
    output logic [BAND_W-1:0] band_o
);
    logic [1:0]        sync_out;
    logic              scl_s, sda_s;
    logic              wr_stb, start_det, stop_det;
    logic [BYTE_W-1:0] wr_byte;
    bus_state_e        fsm_state;

    tpll_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (sync_out)
    );
    assign scl_s = sync_out[1];
    assign sda_s = sync_out[0];

    tpll_bus_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_s        (scl_s),
        .sda_s        (sda_s),
        .addr_sel     (addr_sel_i),
        .lock         (lock_i),
        .adc_code     (adc_code_i),
        .sda_drive_low(sda_drive_low_o),
        .wr_stb       (wr_stb),
        .wr_byte      (wr_byte),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .state_o      (fsm_state)
    );

    tpll_regbank u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start_det),
        .wr_stb  (wr_stb),
        .wr_byte (wr_byte),
        .main_div(main_div_o),
        .swallow (swallow_o),
        .cp_high (cp_high_o),
        .pump_off(pump_off_o),
        .ref_sel (ref_sel_o),
        .vt_off  (vt_off_o),
        .band    (band_o)
    );
endmodule

// File: rtl/tuner_i2c_regs_chk.sv
module tuner_i2c_regs_chk
    import tpll_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input bus_state_e        fsm_state,
    input logic              start_det,
    input logic              stop_det,
    input logic              wr_stb,
    input logic              sda_drive_low_o,
    input logic [MDIV_W-1:0] main_div_o,
    input logic [SWL_W-1:0]  swallow_o,
    input logic [BAND_W-1:0] band_o
);
    assert_div_pair_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(main_div_o) || !$stable(swallow_o)) |-> $past(wr_stb));

    assert_band_pair_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(band_o) |-> $past(wr_stb));

    assert_start_to_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_det) |-> (fsm_state == ST_ADDR));

    assert_stop_to_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> (fsm_state == ST_IDLE));

    assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE) |-> !sda_drive_low_o);

    assert_host_ack_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_RD_ACK) |-> !sda_drive_low_o);
endmodule

bind tuner_i2c_regs tuner_i2c_regs_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fsm_state      (fsm_state),
    .start_det      (start_det),
    .stop_det       (stop_det),
    .wr_stb         (wr_stb),
    .sda_drive_low_o(sda_drive_low_o),
    .main_div_o     (main_div_o),
    .swallow_o      (swallow_o),
    .band_o         (band_o)
);

// File: tb/tuner_i2c_regs_bench.sv
module tuner_i2c_regs_bench;
    localparam int Q = 10;
    localparam int NVEC = 6;
    localparam logic [15:0] VEC [NVEC] = '{16'h3AB7, 16'hCE0A, 16'h7FFF, 16'hA4F5, 16'h0000, 16'hFFFF};

    logic clk = 1'b0;
    logic rst_n, scl, sda_m;
    logic [1:0] addr_sel;
    logic lock;
    logic [2:0] adc;
    logic drive_low, sda_line;
    logic [9:0] main_div;
    logic [4:0] swallow;
    logic cp_high, pump_off, vt_off;
    logic [1:0] ref_sel;
    logic [3:0] band;

    int errs = 0;
    int checks = 0;

    logic [9:0] e_mdiv;
    logic [4:0] e_swl;
    logic e_cp, e_cd, e_os;
    logic [1:0] e_ref;
    logic [3:0] e_band;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~drive_low;

    tuner_i2c_regs u_tuner_i2c_regs (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_drive_low_o(drive_low), .addr_sel_i(addr_sel), .lock_i(lock),
        .adc_code_i(adc), .main_div_o(main_div), .swallow_o(swallow),
        .cp_high_o(cp_high), .pump_off_o(pump_off), .ref_sel_o(ref_sel),
        .vt_off_o(vt_off), .band_o(band)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic write_bit(input logic b);
        sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) write_bit(b[i]);
        sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_line; wq(); scl = 1'b0; wq();
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] d);
        d = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; wq(); scl = 1'b1; wq(); d = {d[6:0], sda_line}; wq(); scl = 1'b0; wq();
        end
        sda_m = nack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); sda_m = 1'b1;
    endtask

    task automatic model_pair(input logic [7:0] b1, input logic [7:0] b2);
        if (b1[7]) begin
            e_cp = b1[6]; e_cd = b1[5]; e_ref = b1[3:2]; e_os = b1[1]; e_band = b2[3:0];
        end else begin
            e_mdiv = {b1[6:0], b2[7:5]}; e_swl = b2[4:0];
        end
    endtask

    task automatic check_regs(input string tag);
        chk(tag, {main_div, swallow, cp_high, pump_off, ref_sel, vt_off, band},
                 {e_mdiv, e_swl, e_cp, e_cd, e_ref, e_os, e_band});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; addr_sel = 2'b10; lock = 1'b0; adc = 3'b000;
        e_mdiv = '0; e_swl = '0; e_cp = 0; e_cd = 0; e_ref = '0; e_os = 0; e_band = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10: reset state
        check_regs("R10 reset registers");
        chk("R10 reset sda released", drive_low, 1'b0);

        // R2 / R3 / R6 / R1: table of pairs
        for (int v = 0; v < NVEC; v++) begin
            i2c_start();
            send_byte(8'hC4, ack); chk("R1 address ack", ack, 1'b1);
            send_byte(VEC[v][15:8], ack); chk("R6 ack byte1", ack, 1'b1);
            send_byte(VEC[v][7:0], ack); chk("R6 ack byte2", ack, 1'b1);
            i2c_stop();
            model_pair(VEC[v][15:8], VEC[v][7:0]);
            check_regs(VEC[v][15] ? "R3 setup/band pair" : "R2 divider pair");
        end

        // R1: neighbour address is ignored
        i2c_start();
        send_byte(8'hC2, ack); chk("R1 wrong address nack", ack, 1'b0);
        send_byte(8'h12, ack); chk("R1 no ack after mismatch", ack, 1'b0);
        send_byte(8'h34, ack);
        i2c_stop();
        check_regs("R1 mismatch no effect");

        // R4: single divider byte, single setup byte
        i2c_start(); send_byte(8'hC4, ack); send_byte(8'h05, ack); i2c_stop();
        check_regs("R4 lone divider byte");
        i2c_start(); send_byte(8'hC4, ack); send_byte(8'h80, ack); i2c_stop();
        check_regs("R4 lone setup byte");

        // R5: two pairs in one write, then a three-byte retune
        i2c_start(); send_byte(8'hC4, ack);
        send_byte(8'h12, ack); send_byte(8'h34, ack);
        send_byte(8'hC3, ack); send_byte(8'h06, ack);
        i2c_stop();
        model_pair(8'h12, 8'h34); model_pair(8'hC3, 8'h06);
        check_regs("R5 five-byte write");
        i2c_start(); send_byte(8'hC4, ack); send_byte(8'h21, ack); send_byte(8'h43, ack); i2c_stop();
        model_pair(8'h21, 8'h43);
        check_regs("R5 three-byte retune");

        // R7: repeated start discards unpaired byte
        i2c_start(); send_byte(8'hC4, ack); send_byte(8'h55, ack);
        i2c_start(); send_byte(8'hC4, ack); chk("R7 repeated start ack", ack, 1'b1);
        send_byte(8'h01, ack); send_byte(8'h02, ack);
        i2c_stop();
        model_pair(8'h01, 8'h02);
        check_regs("R7 fresh pair after repeated start");

        // R8: status byte
        lock = 1'b1; adc = 3'b011;
        i2c_start(); send_byte(8'hC4, ack); send_byte(8'h09, ack);
        i2c_start(); send_byte(8'hC5, ack); chk("R7 read after repeated start ack", ack, 1'b1);
        read_byte(1'b1, d); i2c_stop();
        chk("R8 status locked", d, 8'hFB);
        check_regs("R7 partial before read no effect");
        lock = 1'b0; adc = 3'b100;
        i2c_start(); send_byte(8'hC5, ack); read_byte(1'b1, d); i2c_stop();
        chk("R8 status unlocked", d, 8'hBC);

        // R9: ACK continues, NACK releases
        lock = 1'b1; adc = 3'b001;
        i2c_start(); send_byte(8'hC5, ack);
        read_byte(1'b0, d); chk("R9 first byte", d, 8'hF9);
        read_byte(1'b1, d); chk("R9 second byte after ack", d, 8'hF9);
        chk("R9 released after nack", drive_low, 1'b0);
        read_byte(1'b1, d); chk("R9 no drive after nack", d, 8'hFF);
        i2c_stop();

        // R11: stop inside a byte
        i2c_start(); send_byte(8'hC4, ack); send_byte(8'h33, ack);
        write_bit(1'b0); write_bit(1'b1); write_bit(1'b0); write_bit(1'b0);
        i2c_stop();
        check_regs("R11 stop mid-byte no effect");
        chk("R11 released after stop", drive_low, 1'b0);
        i2c_start(); send_byte(8'hC4, ack); send_byte(8'h0F, ack); send_byte(8'hF0, ack); i2c_stop();
        model_pair(8'h0F, 8'hF0);
        check_regs("R11 write after abort");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule